// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block keeps one address reservation per processor context and decides whether a store-conditional may write memory. A locked load records its address as the reservation of the context that issued it. A later store-conditional from that same context is allowed only while its reservation is still valid and still covers the same 16-byte granule. Any store that does write memory cancels the reservations of every context that were watching that granule. This covers ordinary stores and successful store-conditionals.

The block has one store port and one load port, and each can carry one request per cycle. The store-permit output is combinational in the request cycle, so the memory pipeline can suppress a failing store-conditional at once. The result code for a store-conditional is registered and appears in the next cycle: 0 means failed, 1 means succeeded, and 2 means uncacheable. Each context also counts its consecutive store-conditional failures. A one-cycle warning pulse is raised each time that count reaches another full period, which helps find livelock in retry loops.

Top module: `resv_monitor`

## Requirements
- R1: A synchronous active-high reset clears every reservation and failure count. While reset is held and after it is released, resultValid and failWarn are 0, and a store-conditional from any context fails until a locked load arrives.
- R2: A locked load sets the issuing context's reservation to its address. A later cacheable store-conditional from that context to the same granule drives storePermit to 1 in its request cycle, and the result code in the next cycle is 1.
- R3: Reservations are compared with address bits [3:0] ignored. A store-conditional anywhere inside the reserved 16-byte granule succeeds, and one outside that granule fails.
- R4: A cacheable store-conditional without a matching valid reservation drives storePermit to 0 and returns result code 0. It also clears the issuing context's reservation, so a later store-conditional to the old granule fails as well.
- R5: A store-conditional marked uncacheable drives storePermit to 1 and returns result code 2. It changes no reservation, so a later cacheable store-conditional from the same context still succeeds.
- R6: An ordinary store, or a successful store-conditional, clears the reservation of every context that holds the stored granule, including contexts other than the issuer. Reservations on other granules stay valid.
- R7: A load without the locked flag changes no reservation. An ordinary store always drives storePermit to 1 and produces no result (resultValid stays 0).
- R8: When a store and a locked load target the same granule in the same cycle, the store's clearing is applied first, and the load's new reservation is left valid afterwards.
- R9: Each context counts consecutive cacheable store-conditional failures. The count returns to zero on a success or on an uncacheable store-conditional. failWarn bit n pulses for one cycle, in the cycle the result is valid, each time context n's count reaches a multiple of FAIL_PERIOD.
- R10: resultValid is 1 exactly one cycle after each store-conditional request and is 0 after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stValid | input | 1 | Store request strobe |
| stCtx | input | CTX_W | Context issuing the store |
| stAddr | input | ADDR_W | Physical store address |
| stCond | input | 1 | Store is a store-conditional |
| stUncache | input | 1 | Store targets uncacheable space |
| ldValid | input | 1 | Load request strobe |
| ldCtx | input | CTX_W | Context issuing the load |
| ldAddr | input | ADDR_W | Physical load address |
| ldLocked | input | 1 | Load is a locked load |
| storePermit | output | 1 | Store may write memory (combinational) |
| resultValid | output | 1 | Registered store-conditional result strobe |
| resultCode | output | 2 | 0 fail, 1 success, 2 uncacheable |
| failWarn | output | NUM_CTX | Per-context repeated-failure pulse |

## Verification
The bench builds the block with four contexts, a 16-bit address and FAIL_PERIOD set to 5. The short period means a context reaches two warning thresholds within a few dozen requests. This lets the bench check the reset of the count by a success and by an uncacheable store-conditional, and the wrap-around of the count. The narrow address keeps granule-boundary cases easy to read, and four contexts are enough for one store to clear reservations in several other contexts at once.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [1:0] {
    RES_FAIL     = 2'd0,
    RES_PASS     = 2'd1,
    RES_UNCACHED = 2'd2
  } scResult_e;

  // strobes from control to datapath, one request per port per cycle
  typedef struct packed {
    logic clearMatch;  // clear every context holding the store granule
    logic clearOwn;    // clear the issuing store context only
    logic setResv;     // load the load context's reservation
    logic failInc;     // bump the store context's failure count
    logic failRst;     // zero the store context's failure count
  } resvStrobes_t;

endpackage

// File: rtl/resv_fail_ctr.sv
module resv_fail_ctr #(
  parameter int FAIL_PERIOD = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic clr,
  output logic warn
);
  localparam int CNT_W = (FAIL_PERIOD > 1) ? $clog2(FAIL_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FAIL_PERIOD - 1);

  logic [CNT_W-1:0] failCnt;

  // counts modulo FAIL_PERIOD: wrapping marks each multiple of the period
  always_ff @(posedge clk) begin
    if (rst) begin
      failCnt <= '0;
      warn    <= 1'b0;
    end else begin
      warn <= 1'b0;
      if (clr) begin
        failCnt <= '0;
      end else if (inc) begin
        if (failCnt == LAST) begin
          failCnt <= '0;
          warn    <= 1'b1;
        end else begin
          failCnt <= failCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         stValid,
  input  logic         stCond,
  input  logic         stUncache,
  input  logic         ldValid,
  input  logic         ldLocked,
  input  logic         ownHit,
  output logic         storePermit,
  output resvStrobes_t strb,
  output logic         resultValid,
  output scResult_e    resultCode
);
  logic isSc, scUncached, scPass, scFail, plainStore;
  scResult_e nextCode;

  always_comb begin
    isSc       = stValid & stCond;
    scUncached = isSc & stUncache;
    scPass     = isSc & ~stUncache & ownHit;
    scFail     = isSc & ~stUncache & ~ownHit;
    plainStore = stValid & ~stCond;

    storePermit = plainStore | scUncached | scPass;

    strb.clearMatch = plainStore | scPass;
    strb.clearOwn   = scFail;
    strb.setResv    = ldValid & ldLocked;
    strb.failInc    = scFail;
    strb.failRst    = scPass | scUncached;

    if (scUncached)  nextCode = RES_UNCACHED;
    else if (scPass) nextCode = RES_PASS;
    else             nextCode = RES_FAIL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resultValid <= 1'b0;
      resultCode  <= RES_FAIL;
    end else begin
      resultValid <= isSc;
      resultCode  <= nextCode;
    end
  end
endmodule

// File: rtl/resv_datapath.sv
module resv_datapath
  import resv_pkg::*;
#(
  parameter int NUM_CTX     = 4,
  parameter int ADDR_W      = 64,
  parameter int GRAN_LSB    = 4,
  parameter int FAIL_PERIOD = 100000,
  parameter int CTX_W       = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CTX_W-1:0]   stCtx,
  input  logic [ADDR_W-1:0]  stAddr,
  input  logic [CTX_W-1:0]   ldCtx,
  input  logic [ADDR_W-1:0]  ldAddr,
  input  resvStrobes_t       strb,
  output logic               ownHit,
  output logic [NUM_CTX-1:0] failWarn
);
  localparam int GRAN_W = ADDR_W - GRAN_LSB;

  logic [GRAN_W-1:0]  stGran, ldGran;
  logic [NUM_CTX-1:0] granHit, stSel, ldSel;

  assign stGran = stAddr[ADDR_W-1:GRAN_LSB];
  assign ldGran = ldAddr[ADDR_W-1:GRAN_LSB];

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    logic              resvVld;
    logic [GRAN_W-1:0] resvGran;

    assign stSel[g]   = (stCtx == CTX_W'(g));
    assign ldSel[g]   = (ldCtx == CTX_W'(g));
    assign granHit[g] = resvVld && (resvGran == stGran);

    // a new reservation wins over a same-cycle clear (clear first, then set)
    always_ff @(posedge clk) begin
      if (rst) begin
        resvVld  <= 1'b0;
        resvGran <= '0;
      end else if (strb.setResv && ldSel[g]) begin
        resvVld  <= 1'b1;
        resvGran <= ldGran;
      end else if ((strb.clearMatch && granHit[g]) ||
                   (strb.clearOwn && stSel[g])) begin
        resvVld <= 1'b0;
      end
    end

    resv_fail_ctr #(.FAIL_PERIOD(FAIL_PERIOD)) u_failCtr (
      .clk  (clk),
      .rst  (rst),
      .inc  (strb.failInc && stSel[g]),
      .clr  (strb.failRst && stSel[g]),
      .warn (failWarn[g])
    );
  end

  assign ownHit = |(granHit & stSel);
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int NUM_CTX     = 4,
  parameter int ADDR_W      = 64,
  parameter int GRAN_LSB    = 4,
  parameter int FAIL_PERIOD = 100000,
  localparam int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stValid,
  input  logic [CTX_W-1:0]   stCtx,
  input  logic [ADDR_W-1:0]  stAddr,
  input  logic               stCond,
  input  logic               stUncache,
  input  logic               ldValid,
  input  logic [CTX_W-1:0]   ldCtx,
  input  logic [ADDR_W-1:0]  ldAddr,
  input  logic               ldLocked,
  output logic               storePermit,
  output logic               resultValid,
  output logic [1:0]         resultCode,
  output logic [NUM_CTX-1:0] failWarn
);
  resvStrobes_t strb;
  scResult_e    resCode;
  logic         ownHit;

  resv_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .stValid     (stValid),
    .stCond      (stCond),
    .stUncache   (stUncache),
    .ldValid     (ldValid),
    .ldLocked    (ldLocked),
    .ownHit      (ownHit),
    .storePermit (storePermit),
    .strb        (strb),
    .resultValid (resultValid),
    .resultCode  (resCode)
  );

  resv_datapath #(
    .NUM_CTX     (NUM_CTX),
    .ADDR_W      (ADDR_W),
    .GRAN_LSB    (GRAN_LSB),
    .FAIL_PERIOD (FAIL_PERIOD),
    .CTX_W       (CTX_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .stCtx    (stCtx),
    .stAddr   (stAddr),
    .ldCtx    (ldCtx),
    .ldAddr   (ldAddr),
    .strb     (strb),
    .ownHit   (ownHit),
    .failWarn (failWarn)
  );

  assign resultCode = resCode;
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk
  import resv_pkg::*;
#(
  parameter int NUM_CTX = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               stValid,
  input logic               stCond,
  input logic               stUncache,
  input logic               storePermit,
  input logic               resultValid,
  input logic [1:0]         resultCode,
  input logic [NUM_CTX-1:0] failWarn
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!resultValid && failWarn == '0));

  p_pass_code_r2: assert property (@(posedge clk) disable iff (rst)
    (stValid && stCond && !stUncache && storePermit) |=> (resultCode == RES_PASS));

  p_fail_code_r4: assert property (@(posedge clk) disable iff (rst)
    (stValid && stCond && !stUncache && !storePermit) |=> (resultCode == RES_FAIL));

  p_uncached_permit_r5: assert property (@(posedge clk) disable iff (rst)
    (stValid && stCond && stUncache) |-> storePermit);

  p_uncached_code_r5: assert property (@(posedge clk) disable iff (rst)
    (stValid && stCond && stUncache) |=> (resultCode == RES_UNCACHED));

  p_plain_permit_r7: assert property (@(posedge clk) disable iff (rst)
    (stValid && !stCond) |-> storePermit);

  p_warn_single_r9: assert property (@(posedge clk) disable iff (rst)
    $countones(failWarn) <= 1);

  p_warn_on_fail_r9: assert property (@(posedge clk) disable iff (rst)
    (failWarn != '0) |-> (resultValid && resultCode == RES_FAIL));

  p_result_on_sc_r10: assert property (@(posedge clk) disable iff (rst)
    (stValid && stCond) |=> resultValid);

  p_no_result_r10: assert property (@(posedge clk) disable iff (rst)
    !(stValid && stCond) |=> !resultValid);
endmodule

bind resv_monitor resv_monitor_chk #(.NUM_CTX(NUM_CTX)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .stValid     (stValid),
  .stCond      (stCond),
  .stUncache   (stUncache),
  .storePermit (storePermit),
  .resultValid (resultValid),
  .resultCode  (resultCode),
  .failWarn    (failWarn)
);

// File: tb/resv_monitor_bench.sv
`timescale 1ns/1ps
module resv_monitor_bench;
  localparam int NC     = 4;
  localparam int AW     = 16;
  localparam int GL     = 4;
  localparam int PERIOD = 5;
  localparam int CW     = 2;

  localparam logic [AW-1:0] A = 16'h1230;
  localparam logic [AW-1:0] B = 16'h1240;

  logic          clk = 1'b0;
  logic          rst;
  logic          stValid, stCond, stUncache, ldValid, ldLocked;
  logic [CW-1:0] stCtx, ldCtx;
  logic [AW-1:0] stAddr, ldAddr;
  logic          storePermit, resultValid;
  logic [1:0]    resultCode;
  logic [NC-1:0] failWarn;

  int checks = 0;
  int errors = 0;

  // reference model built from the requirements
  bit               mVal  [NC];
  logic [AW-1:GL]   mGran [NC];
  int               mCnt  [NC];

  always #5 clk = ~clk;

  resv_monitor #(.NUM_CTX(NC), .ADDR_W(AW), .GRAN_LSB(GL), .FAIL_PERIOD(PERIOD)) u_resv_monitor (
    .clk(clk), .rst(rst),
    .stValid(stValid), .stCtx(stCtx), .stAddr(stAddr), .stCond(stCond), .stUncache(stUncache),
    .ldValid(ldValid), .ldCtx(ldCtx), .ldAddr(ldAddr), .ldLocked(ldLocked),
    .storePermit(storePermit), .resultValid(resultValid), .resultCode(resultCode),
    .failWarn(failWarn)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    stValid = 0; stCond = 0; stUncache = 0; stCtx = '0; stAddr = '0;
    ldValid = 0; ldLocked = 0; ldCtx = '0; ldAddr = '0;
  endtask

  // one request cycle on either or both ports, checked against the model
  task automatic step(input bit sv, input int sc, input logic [AW-1:0] sa,
                      input bit cond, input bit unc,
                      input bit lv, input int lc, input logic [AW-1:0] la,
                      input bit lk, input string tag);
    logic          expP, expRv;
    logic [1:0]    expCode;
    logic [NC-1:0] expW;
    expP = 0; expRv = 0; expCode = 0; expW = '0;
    if (sv) begin
      if (cond && unc) begin
        expP = 1; expRv = 1; expCode = 2; mCnt[sc] = 0;
      end else if (cond) begin
        expRv = 1;
        if (mVal[sc] && mGran[sc] == sa[AW-1:GL]) begin
          expP = 1; expCode = 1; mCnt[sc] = 0;
          for (int i = 0; i < NC; i++) if (mGran[i] == sa[AW-1:GL]) mVal[i] = 0;
        end else begin
          mVal[sc] = 0; mCnt[sc]++;
          if (mCnt[sc] == PERIOD) begin mCnt[sc] = 0; expW[sc] = 1'b1; end
        end
      end else begin
        expP = 1;
        for (int i = 0; i < NC; i++) if (mGran[i] == sa[AW-1:GL]) mVal[i] = 0;
      end
    end
    if (lv && lk) begin mVal[lc] = 1; mGran[lc] = la[AW-1:GL]; end

    stValid = sv; stCtx = sc[CW-1:0]; stAddr = sa; stCond = cond; stUncache = unc;
    ldValid = lv; ldCtx = lc[CW-1:0]; ldAddr = la; ldLocked = lk;
    #1;
    chk(storePermit === expP, tag, "storePermit", 32'(storePermit), 32'(expP));
    @(posedge clk);
    #1;
    chk(resultValid === expRv, tag, "resultValid", 32'(resultValid), 32'(expRv));
    if (expRv) chk(resultCode === expCode, tag, "resultCode", 32'(resultCode), 32'(expCode));
    chk(failWarn === expW, tag, "failWarn", 32'(failWarn), 32'(expW));
    idle();
    @(negedge clk);
  endtask

  task automatic lockLd(input int c, input logic [AW-1:0] a, input string tag);
    step(0, 0, '0, 0, 0, 1, c, a, 1, tag);
  endtask
  task automatic plainLd(input int c, input logic [AW-1:0] a, input string tag);
    step(0, 0, '0, 0, 0, 1, c, a, 0, tag);
  endtask
  task automatic scSt(input int c, input logic [AW-1:0] a, input string tag);
    step(1, c, a, 1, 0, 0, 0, '0, 0, tag);
  endtask
  task automatic scUnc(input int c, input logic [AW-1:0] a, input string tag);
    step(1, c, a, 1, 1, 0, 0, '0, 0, tag);
  endtask
  task automatic plainSt(input int c, input logic [AW-1:0] a, input string tag);
    step(1, c, a, 0, 0, 0, 0, '0, 0, tag);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NC; i++) begin mVal[i] = 0; mGran[i] = '0; mCnt[i] = 0; end
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    chk(resultValid === 1'b0, "R1", "resultValid in reset", 32'(resultValid), 0);
    chk(failWarn === '0, "R1", "failWarn in reset", 32'(failWarn), 0);
    @(negedge clk);
    rst = 0;
    for (int c = 0; c < NC; c++) scSt(c, A, "R1");
  endtask

  task automatic t_basic();
    lockLd(1, A, "R2");
    scSt(1, A, "R2");
    scSt(1, A, "R10");
  endtask

  task automatic t_gran();
    lockLd(2, A + 16'h5, "R3");
    scSt(2, A + 16'hF, "R3");
    lockLd(2, A, "R3");
    scSt(2, B, "R3");
  endtask

  task automatic t_fail();
    lockLd(3, A, "R4");
    scSt(3, B, "R4");
    scSt(3, A, "R4");
  endtask

  task automatic t_uncached();
    lockLd(0, A, "R5");
    scUnc(0, A, "R5");
    scSt(0, A, "R5");
  endtask

  task automatic t_clear();
    lockLd(0, A, "R6");
    lockLd(1, A + 16'h8, "R6");
    lockLd(2, B, "R6");
    plainSt(3, A + 16'h3, "R6");
    scSt(0, A, "R6");
    scSt(1, A, "R6");
    scSt(2, B, "R6");
    lockLd(0, A, "R6");
    lockLd(1, A, "R6");
    scSt(0, A, "R6");
    scSt(1, A, "R6");
  endtask

  task automatic t_plain();
    lockLd(1, A, "R7");
    plainLd(1, B, "R7");
    plainSt(2, B, "R7");
    scSt(1, A, "R7");
  endtask

  task automatic t_same();
    step(1, 0, A, 0, 0, 1, 1, A + 16'h4, 1, "R8");
    scSt(1, A, "R8");
    lockLd(2, B, "R8");
    step(1, 2, B, 1, 0, 1, 3, B, 1, "R8");
    scSt(3, B, "R8");
  endtask

  task automatic t_warn();
    scUnc(3, A, "R9");
    for (int i = 0; i < 2 * PERIOD; i++) scSt(3, B, "R9");
    for (int i = 0; i < 3; i++) scSt(3, B, "R9");
    lockLd(3, A, "R9");
    scSt(3, A, "R9");
    for (int i = 0; i < PERIOD; i++) scSt(3, B, "R9");
    for (int i = 0; i < 2; i++) scSt(3, B, "R9");
    scUnc(3, B, "R9");
    for (int i = 0; i < PERIOD; i++) scSt(3, B, "R9");
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1;
    idle();
    @(negedge clk);
    t_reset();
    t_basic();
    t_gran();
    t_fail();
    t_uncached();
    t_clear();
    t_plain();
    t_same();
    t_warn();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule